// File: doc/BRIEF.md
# Steered-Toggle Decade Counter

This block counts input ticks from zero to nine and wraps, and it does so the way a chain of toggle stages would rather than through an adder. Each of the four count bits is a toggle stage that changes state only when its chosen source produces a falling event. The steering that picks each source is what turns a plain divide-by-sixteen chain into a divide-by-ten. No state is ever forced to zero.

Everything runs in one system clock domain. A one-cycle `tick_i` strobe stands in for the falling input edge. All toggles that a single tick causes settle within one clock cycle. The four count bits change on the clock edge that samples the tick. Alongside them, `carry_o` pulses for one cycle when the top bit drops, so the strobe can advance a following digit stage.

The steering is as follows. The least significant stage follows the tick. Stage 1 follows the fall of stage 0, but only while the top bit is low. Stage 2 follows the fall of stage 1. The top stage uses a selector that is steered by its own value: while it is low it takes the fall of stage 2, and while it is high it takes the fall of stage 0.

Top module: `decade_steer_counter`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0 and `carry_o` is 0. Both stay at 0 until the first sampled tick after `rst_n` goes high.
- R2: In a cycle where `tick_i` is low, `count_o` holds its value at the next clock edge.
- R3: Each sampled tick inverts `count_o[0]` at that clock edge.
- R4: Each sampled tick moves `count_o` (unsigned, bit 0 least significant, weights 1-2-4-8) from n to n+1 for n below 9. It moves it from 9 to 0.
- R5: While `count_o[3]` is 1, `count_o[2:1]` is 0. The fall of bit 0 on the ninth-to-zero tick does not toggle bit 1.
- R6: `count_o` never takes a value from 10 to 15 after reset.
- R7: `carry_o` is 1 in exactly the cycles where `count_o[3]` has just gone from 1 to 0. It is never high for two cycles in a row when ticks are spaced.
- R8: Over any run from reset, the number of `carry_o` pulses equals the number of ticks divided by ten, rounded down.
- R9: The cascaded transitions 7→8 and 9→0 complete in the single cycle after their tick, including when ticks arrive on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_i | input | 1 | One-cycle strobe standing for a falling input edge |
| count_o | output | 4 | Count bits, weights 8-4-2-1 from bit 3 down to bit 0 |
| carry_o | output | 1 | One-cycle strobe on the fall of the top count bit |

## Verification
The bench builds the block with the package defaults: four toggle stages, a top index of 3 and a wrap after nine. These defaults bring every legal state, both multi-stage cascades (7→8 and 9→0) and the self-steered clear of the top bit within reach. Spaced ticks, back-to-back ticks and a long run with irregular gaps exercise the hold, step and carry rules. Resets that land mid-count, and one that lands on the wrap tick, show that reset wins over the carry.

// File: rtl/dec_pkg.sv
package dec_pkg;

  // Number of toggle stages in one decade digit.
  localparam int unsigned CNT_W   = 4;
  // Index of the most significant stage, which also steers the chain.
  localparam int unsigned TOP_IDX = CNT_W - 1;
  // Last legal count before wrapping to zero.
  localparam int unsigned WRAP_AT = 9;

  typedef logic [CNT_W-1:0] cnt_t;

  // Where each toggle stage takes its falling event from.
  typedef enum logic [1:0] {
    SRC_TICK    = 2'd0,  // the input strobe itself
    SRC_MASKED  = 2'd1,  // previous stage's fall, blocked while top bit high
    SRC_PREV    = 2'd2,  // previous stage's fall, ungated
    SRC_SELFSEL = 2'd3   // selector: prev-stage fall when low, stage-0 fall when high
  } steer_src_e;

  function automatic steer_src_e steer_of(input int unsigned idx);
    steer_src_e s;
    if (idx == 0)            s = SRC_TICK;
    else if (idx == TOP_IDX) s = SRC_SELFSEL;
    else if (idx == 1)       s = SRC_MASKED;
    else                     s = SRC_PREV;
    return s;
  endfunction

endpackage

// File: rtl/dec_toggle_stage.sv
module dec_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  // Next state: invert on a steered falling event, otherwise hold.
  always_comb begin
    q_d = q_q;
    if (step_i) q_d = ~q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/dec_steer_net.sv
module dec_steer_net
  import dec_pkg::*;
(
  input  logic tick_i,
  input  cnt_t q_i,
  output cnt_t step_o,
  output logic top_fall_o
);

  cnt_t step_v;
  cnt_t fall_v;

  // Walk the chain from the least significant stage upward. A stage's fall
  // event is its step while it currently holds a one.
  always_comb begin
    step_v = '0;
    fall_v = '0;
    for (int i = 0; i < int'(CNT_W); i++) begin
      case (steer_of(i))
        SRC_TICK:    step_v[i] = tick_i;
        SRC_MASKED:  step_v[i] = (i > 0) ? (fall_v[i-1] & ~q_i[TOP_IDX]) : 1'b0;
        SRC_PREV:    step_v[i] = (i > 0) ? fall_v[i-1] : 1'b0;
        SRC_SELFSEL: step_v[i] = q_i[i] ? fall_v[0] : ((i > 0) ? fall_v[i-1] : 1'b0);
        default:     step_v[i] = 1'b0;
      endcase
      fall_v[i] = q_i[i] & step_v[i];
    end
  end

  assign step_o     = step_v;
  assign top_fall_o = fall_v[TOP_IDX];

endmodule

// File: rtl/decade_steer_counter.sv
module decade_steer_counter
  import dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  output logic [3:0] count_o,
  output logic       carry_o
);

  cnt_t q;
  cnt_t step;
  logic top_fall;
  logic carry_q;
  logic carry_d;

  dec_steer_net u_steer (
    .tick_i     (tick_i),
    .q_i        (q),
    .step_o     (step),
    .top_fall_o (top_fall)
  );

  for (genvar g = 0; g < int'(CNT_W); g++) begin : g_stage
    dec_toggle_stage u_tff (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step[g]),
      .q_o    (q[g])
    );
  end

  // Carry strobe lines up with the cycle in which the top bit reads low again.
  always_comb begin
    carry_d = top_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  assign count_o = q;
  assign carry_o = carry_q;

endmodule

// File: rtl/decade_steer_counter_chk.sv
module decade_steer_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic [3:0] count_o,
  input logic       carry_o
);

  // R1: outputs are cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (count_o == 4'd0 && !carry_o));

  // R2: no tick, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_o));

  // R3: every tick flips the lowest bit
  a_r3_lsb_flip: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (count_o[0] != $past(count_o[0])));

  // R4 and R9: one decimal step per tick, settled in one cycle
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (count_o == (($past(count_o) == 4'd9) ? 4'd0 : $past(count_o) + 4'd1)));

  // R5: middle bits held low while the top bit is set
  a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
    count_o[3] |-> (count_o[2:1] == 2'b00));

  // R6: no illegal code
  a_r6_legal: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= 4'd9);

  // R7: carry marks the fall of the top bit, both directions
  a_r7_carry_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(count_o[3]) |-> carry_o);
  a_r7_carry_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> $fell(count_o[3]));

endmodule

bind decade_steer_counter decade_steer_counter_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_i  (tick_i),
  .count_o (count_o),
  .carry_o (carry_o)
);

// File: tb/decade_steer_counter_tb.sv
module decade_steer_counter_tb;

  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic [3:0] count_o;
  logic       carry_o;

  int n_checks;
  int n_errors;
  int ref_cnt;
  int ticks_seen;
  int carries_seen;

  decade_steer_counter u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .count_o (count_o),
    .carry_o (carry_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {tick, expected count, expected carry}
  localparam int NVEC = 17;
  localparam logic [5:0] VEC [NVEC] = '{
    {1'b1, 4'd1, 1'b0}, {1'b0, 4'd1, 1'b0}, {1'b1, 4'd2, 1'b0},
    {1'b1, 4'd3, 1'b0}, {1'b1, 4'd4, 1'b0}, {1'b0, 4'd4, 1'b0},
    {1'b1, 4'd5, 1'b0}, {1'b1, 4'd6, 1'b0}, {1'b1, 4'd7, 1'b0},
    {1'b0, 4'd7, 1'b0}, {1'b1, 4'd8, 1'b0}, {1'b0, 4'd8, 1'b0},
    {1'b1, 4'd9, 1'b0}, {1'b0, 4'd9, 1'b0}, {1'b1, 4'd0, 1'b1},
    {1'b0, 4'd0, 1'b0}, {1'b1, 4'd1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; outputs are read on the next falling edge.
  task automatic cycle(input logic t);
    tick_i = t;
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 count in reset", count_o, 0);
    check("R1 carry in reset", carry_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_cnt = 0;
  endtask

  // Reference step shared by the long-run checks.
  task automatic ref_cycle(input logic t, input string req);
    logic exp_carry;
    exp_carry = 1'b0;
    cycle(t);
    if (t) begin
      ticks_seen++;
      if (ref_cnt == 9) begin ref_cnt = 0; exp_carry = 1'b1; end
      else ref_cnt++;
    end
    if (carry_o) carries_seen++;
    check(req, count_o, ref_cnt);
    check("R7 carry", carry_o, exp_carry);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0; ref_cnt = 0;
    ticks_seen = 0; carries_seen = 0;
    tick_i = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset count", count_o, 0);
    check("R1 reset carry", carry_o, 0);
    rst_n = 1'b1;
    cycle(1'b0);
    check("R1 idle after release", count_o, 0);

    // Vector table: R2 R3 R4 R5 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][5]);
      check("R4 table count", count_o, int'(VEC[i][4:1]));
      check("R7 table carry", carry_o, int'(VEC[i][0]));
      if (count_o[3]) check("R5 middle bits", int'(count_o[2:1]), 0);
    end

    // Back-to-back ticks through two wraps: R9
    do_reset();
    ticks_seen = 0; carries_seen = 0;
    for (int i = 0; i < 25; i++) ref_cycle(1'b1, "R9 back-to-back");
    check("R8 carries back-to-back", carries_seen, ticks_seen / 10);

    // Long run with irregular gaps: R2 R4 R6 R8
    do_reset();
    ticks_seen = 0; carries_seen = 0;
    for (int i = 0; i < 400; i++) begin
      ref_cycle(((i * 7 + i / 3) % 5) != 0, "R4 long run");
      check("R6 legal", int'(count_o <= 4'd9), 1);
    end
    check("R8 carries long run", carries_seen, ticks_seen / 10);

    // Reset mid-count at 7: R1
    do_reset();
    for (int i = 0; i < 7; i++) cycle(1'b1);
    check("R4 reached 7", count_o, 7);
    do_reset();
    cycle(1'b0);
    check("R1 cleared from 7", count_o, 0);

    // Reset landing on the wrap tick suppresses the carry: R1
    for (int i = 0; i < 9; i++) cycle(1'b1);
    check("R4 reached 9", count_o, 9);
    tick_i = 1'b1;
    rst_n  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0;
    check("R1 carry suppressed", carry_o, 0);
    check("R1 count after reset on wrap", count_o, 0);
    rst_n = 1'b1;
    cycle(1'b0);
    check("R1 carry still low", carry_o, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule